// File: doc/BRIEF.md
# Round-Robin Arbiter for Shared AXI4-Lite Slave

This block lets a fixed number of AXI4-Lite masters share a single AXI4-Lite slave port. Two independent round-robin arbiters run side by side. One decides which master owns the write path (write address, write data and write response channels). The other decides which master owns the read path (read address and read data channels). The owning master's request channels are steered to the slave. The slave's ready signals and response valids are returned to that master alone. Every other master sees ready and response valid held low.

A path is claimed when a master raises its address valid while that path is idle. The claim registers on the next clock edge, and the grant is locked until the slave's response handshake for that transaction completes. The next owner is chosen only at that transaction boundary. A master that asks again in the very first cycle after its own response keeps the path, so a burst of back-to-back accesses from one master completes without interleaving. A master that pauses for even one cycle lets priority move to the next requesting master after it, with wrap-around.

Top module: `axil_rr_share`

## Requirements
- R1: While a master owns the write path, the slave's write-address and write-data channels carry that master's valid, address, data and strobe unchanged. An idle path is claimed on the clock edge after a master's write-address valid is seen.
- R2: A write-path grant stays with its owner from the claim until the slave's write-response handshake. This holds for any slave response latency. Meanwhile the other masters see write-address ready, write-data ready and response valid held low, and none of their write-address valids reaches the slave.
- R3: If the owner raises its address valid again in the first cycle after its response handshake, it keeps the path. With all masters busy, four back-to-back accesses from master 0 finish before master 1 is served.
- R4: Otherwise the next owner is the first requesting master after the previous owner, in rising index order with wrap-around from the highest index to 0. With a one-cycle gap between each master's accesses, service rotates 0, 1, 2, 0, 1, 2.
- R5: With no grant held, the slave-side request valids (write address, write data, read address) stay low and no master sees a response valid.
- R6: The read path has its own arbiter that follows R1 to R4 using read-address valid and the read-data handshake. A read from one master and a write from another can be in progress at the same time.
- R7: Write-response and read-data valids reach only the owning master. Response codes and read data pass through unchanged.
- R8: After reset no path is granted, all master-side readies and response valids are low, and the first arbitration gives master 0 the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mAwValid | input | N | Write-address valid, one bit per master |
| mAwAddr | input | N*AW | Write addresses, master i at bits [i*AW +: AW] |
| mAwReady | output | N | Write-address ready per master |
| mWValid | input | N | Write-data valid per master |
| mWData | input | N*DW | Write data, master i at bits [i*DW +: DW] |
| mWStrb | input | N*DW/8 | Byte strobes, master i at bits [i*DW/8 +: DW/8] |
| mWReady | output | N | Write-data ready per master |
| mBValid | output | N | Write-response valid per master |
| mBReady | input | N | Write-response ready per master |
| mBResp | output | 2 | Write-response code, shared |
| mArValid | input | N | Read-address valid per master |
| mArAddr | input | N*AW | Read addresses, master i at bits [i*AW +: AW] |
| mArReady | output | N | Read-address ready per master |
| mRValid | output | N | Read-data valid per master |
| mRReady | input | N | Read-data ready per master |
| mRData | output | DW | Read data, shared |
| mRResp | output | 2 | Read-response code, shared |
| sAwValid | output | 1 | Slave write-address valid |
| sAwAddr | output | AW | Slave write address |
| sAwReady | input | 1 | Slave write-address ready |
| sWValid | output | 1 | Slave write-data valid |
| sWData | output | DW | Slave write data |
| sWStrb | output | DW/8 | Slave byte strobes |
| sWReady | input | 1 | Slave write-data ready |
| sBValid | input | 1 | Slave write-response valid |
| sBReady | output | 1 | Slave write-response ready |
| sBResp | input | 2 | Slave write-response code |
| sArValid | output | 1 | Slave read-address valid |
| sArAddr | output | AW | Slave read address |
| sArReady | input | 1 | Slave read-address ready |
| sRValid | input | 1 | Slave read-data valid |
| sRReady | output | 1 | Slave read-data ready |
| sRData | input | DW | Slave read data |
| sRResp | input | 2 | Slave read-response code |

## Verification
All three masters stream four accesses each. The streams use no gap between accesses or a one-cycle gap, and the slave answers with zero or three cycles of response latency. The slave-side order of addresses then shows whether the arbiter keeps the path for an immediate re-request (grouped order) or rotates with wrap-around (interleaved order), and shows that latency does not change either order. A directed case has a second master request while the first waits on a slow response, to show that the lock holds. A mixed case has one master writing while another reads, to show that the two paths run concurrently. Read data and response codes are compared against values derived from the address, to confirm that responses are steered to the right master.

// File: rtl/axil_rr_pkg.sv
package axil_rr_pkg;
  // Widest master index the grant struct can carry (up to 2**OWNER_W masters).
  localparam int unsigned OWNER_W = 4;
  typedef logic [OWNER_W-1:0] owner_t;

  // Control -> datapath: who owns each path.
  typedef struct packed {
    logic   wrBusy;
    owner_t wrOwner;
    logic   rdBusy;
    owner_t rdOwner;
  } grant_s;

  // Datapath -> control: response handshakes that close a transaction.
  typedef struct packed {
    logic wrDone;
    logic rdDone;
  } done_s;
endpackage

// File: rtl/axil_rr_arb.sv
module axil_rr_arb
  import axil_rr_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  logic         done,
  output logic         busy,
  output owner_t       owner
);
  localparam int unsigned SLOTS = 2 ** OWNER_W;

  logic             busyQ;
  logic             lingerQ;
  owner_t           ownerQ;
  owner_t           pick;
  logic             found;
  logic [SLOTS-1:0] reqPad;

  assign reqPad = SLOTS'(req);

  // Re-request right after release keeps the path; otherwise search forward
  // from the previous owner with wrap-around.
  always_comb begin
    int     sum;
    owner_t cand;
    pick  = ownerQ;
    found = 1'b0;
    if (lingerQ && reqPad[ownerQ]) begin
      found = 1'b1;
    end
    for (int k = 1; k <= int'(N); k++) begin
      sum = int'(ownerQ) + k;
      if (sum >= int'(N)) sum = sum - int'(N);
      cand = owner_t'(sum);
      if (!found && reqPad[cand]) begin
        pick  = cand;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      lingerQ <= 1'b0;
      ownerQ  <= owner_t'(N - 1);
    end else if (busyQ) begin
      if (done) begin
        busyQ   <= 1'b0;
        lingerQ <= 1'b1;
      end
    end else begin
      lingerQ <= 1'b0;
      if (found) begin
        busyQ  <= 1'b1;
        ownerQ <= pick;
      end
    end
  end

  assign busy  = busyQ;
  assign owner = ownerQ;
endmodule

// File: rtl/axil_rr_ctrl.sv
module axil_rr_ctrl
  import axil_rr_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] wrReq,
  input  logic [N-1:0] rdReq,
  input  done_s        doneS,
  output grant_s       grantQ
);
  logic   wrBusy, rdBusy;
  owner_t wrOwner, rdOwner;

  axil_rr_arb #(.N(N)) u_wrArb (
    .clk(clk), .rstN(rstN), .req(wrReq), .done(doneS.wrDone),
    .busy(wrBusy), .owner(wrOwner)
  );

  axil_rr_arb #(.N(N)) u_rdArb (
    .clk(clk), .rstN(rstN), .req(rdReq), .done(doneS.rdDone),
    .busy(rdBusy), .owner(rdOwner)
  );

  assign grantQ = '{wrBusy: wrBusy, wrOwner: wrOwner, rdBusy: rdBusy, rdOwner: rdOwner};
endmodule

// File: rtl/axil_rr_mux.sv
module axil_rr_mux
  import axil_rr_pkg::*;
#(
  parameter int unsigned N  = 3,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  grant_s            grantQ,
  output done_s             doneS,
  input  logic [N-1:0]      mAwValid,
  input  logic [N*AW-1:0]   mAwAddr,
  output logic [N-1:0]      mAwReady,
  input  logic [N-1:0]      mWValid,
  input  logic [N*DW-1:0]   mWData,
  input  logic [N*DW/8-1:0] mWStrb,
  output logic [N-1:0]      mWReady,
  output logic [N-1:0]      mBValid,
  input  logic [N-1:0]      mBReady,
  output logic [1:0]        mBResp,
  input  logic [N-1:0]      mArValid,
  input  logic [N*AW-1:0]   mArAddr,
  output logic [N-1:0]      mArReady,
  output logic [N-1:0]      mRValid,
  input  logic [N-1:0]      mRReady,
  output logic [DW-1:0]     mRData,
  output logic [1:0]        mRResp,
  output logic              sAwValid,
  output logic [AW-1:0]     sAwAddr,
  input  logic              sAwReady,
  output logic              sWValid,
  output logic [DW-1:0]     sWData,
  output logic [DW/8-1:0]   sWStrb,
  input  logic              sWReady,
  input  logic              sBValid,
  output logic              sBReady,
  input  logic [1:0]        sBResp,
  output logic              sArValid,
  output logic [AW-1:0]     sArAddr,
  input  logic              sArReady,
  input  logic              sRValid,
  output logic              sRReady,
  input  logic [DW-1:0]     sRData,
  input  logic [1:0]        sRResp
);
  localparam int unsigned SW = DW / 8;

  // Write path steering
  always_comb begin
    logic sel;
    sAwValid = 1'b0;
    sAwAddr  = '0;
    sWValid  = 1'b0;
    sWData   = '0;
    sWStrb   = '0;
    sBReady  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      sel         = grantQ.wrBusy && (grantQ.wrOwner == owner_t'(i));
      mAwReady[i] = sel && sAwReady;
      mWReady[i]  = sel && sWReady;
      mBValid[i]  = sel && sBValid;
      if (sel) begin
        sAwValid = mAwValid[i];
        sAwAddr  = mAwAddr[i*AW +: AW];
        sWValid  = mWValid[i];
        sWData   = mWData[i*DW +: DW];
        sWStrb   = mWStrb[i*SW +: SW];
        sBReady  = mBReady[i];
      end
    end
  end

  // Read path steering
  always_comb begin
    logic sel;
    sArValid = 1'b0;
    sArAddr  = '0;
    sRReady  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      sel         = grantQ.rdBusy && (grantQ.rdOwner == owner_t'(i));
      mArReady[i] = sel && sArReady;
      mRValid[i]  = sel && sRValid;
      if (sel) begin
        sArValid = mArValid[i];
        sArAddr  = mArAddr[i*AW +: AW];
        sRReady  = mRReady[i];
      end
    end
  end

  assign mBResp       = sBResp;
  assign mRData       = sRData;
  assign mRResp       = sRResp;
  assign doneS.wrDone = grantQ.wrBusy && sBValid && sBReady;
  assign doneS.rdDone = grantQ.rdBusy && sRValid && sRReady;
endmodule

// File: rtl/axil_rr_share.sv
module axil_rr_share
  import axil_rr_pkg::*;
#(
  parameter int unsigned N  = 3,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      mAwValid,
  input  logic [N*AW-1:0]   mAwAddr,
  output logic [N-1:0]      mAwReady,
  input  logic [N-1:0]      mWValid,
  input  logic [N*DW-1:0]   mWData,
  input  logic [N*DW/8-1:0] mWStrb,
  output logic [N-1:0]      mWReady,
  output logic [N-1:0]      mBValid,
  input  logic [N-1:0]      mBReady,
  output logic [1:0]        mBResp,
  input  logic [N-1:0]      mArValid,
  input  logic [N*AW-1:0]   mArAddr,
  output logic [N-1:0]      mArReady,
  output logic [N-1:0]      mRValid,
  input  logic [N-1:0]      mRReady,
  output logic [DW-1:0]     mRData,
  output logic [1:0]        mRResp,
  output logic              sAwValid,
  output logic [AW-1:0]     sAwAddr,
  input  logic              sAwReady,
  output logic              sWValid,
  output logic [DW-1:0]     sWData,
  output logic [DW/8-1:0]   sWStrb,
  input  logic              sWReady,
  input  logic              sBValid,
  output logic              sBReady,
  input  logic [1:0]        sBResp,
  output logic              sArValid,
  output logic [AW-1:0]     sArAddr,
  input  logic              sArReady,
  input  logic              sRValid,
  output logic              sRReady,
  input  logic [DW-1:0]     sRData,
  input  logic [1:0]        sRResp
);
  grant_s grantQ;
  done_s  doneS;

  axil_rr_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(mAwValid), .rdReq(mArValid),
    .doneS(doneS), .grantQ(grantQ)
  );

  axil_rr_mux #(.N(N), .AW(AW), .DW(DW)) u_mux (
    .grantQ(grantQ), .doneS(doneS),
    .mAwValid(mAwValid), .mAwAddr(mAwAddr), .mAwReady(mAwReady),
    .mWValid(mWValid), .mWData(mWData), .mWStrb(mWStrb), .mWReady(mWReady),
    .mBValid(mBValid), .mBReady(mBReady), .mBResp(mBResp),
    .mArValid(mArValid), .mArAddr(mArAddr), .mArReady(mArReady),
    .mRValid(mRValid), .mRReady(mRReady), .mRData(mRData), .mRResp(mRResp),
    .sAwValid(sAwValid), .sAwAddr(sAwAddr), .sAwReady(sAwReady),
    .sWValid(sWValid), .sWData(sWData), .sWStrb(sWStrb), .sWReady(sWReady),
    .sBValid(sBValid), .sBReady(sBReady), .sBResp(sBResp),
    .sArValid(sArValid), .sArAddr(sArAddr), .sArReady(sArReady),
    .sRValid(sRValid), .sRReady(sRReady), .sRData(sRData), .sRResp(sRResp)
  );
endmodule

// File: rtl/axil_rr_share_chk.sv
module axil_rr_share_chk
  import axil_rr_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input logic         clk,
  input logic         rstN,
  input grant_s       grantQ,
  input logic [N-1:0] mAwReady,
  input logic [N-1:0] mWReady,
  input logic [N-1:0] mBValid,
  input logic [N-1:0] mArReady,
  input logic [N-1:0] mRValid,
  input logic         sAwValid,
  input logic         sWValid,
  input logic         sArValid,
  input logic         sBValid,
  input logic         sBReady,
  input logic         sRValid,
  input logic         sRReady
);
  assert_single_wr_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mAwReady) && $onehot0(mWReady) && $onehot0(mBValid));

  assert_single_rd_owner_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mArReady) && $onehot0(mRValid));

  assert_wr_lock_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ.wrBusy && !(sBValid && sBReady)) |=> (grantQ.wrBusy && $stable(grantQ.wrOwner)));

  assert_wr_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ.wrBusy && sBValid && sBReady) |=> !grantQ.wrBusy);

  assert_rd_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ.rdBusy && !(sRValid && sRReady)) |=> (grantQ.rdBusy && $stable(grantQ.rdOwner)));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!grantQ.wrBusy && !grantQ.rdBusy) |-> (!sAwValid && !sWValid && !sArValid
                                            && mBValid == '0 && mRValid == '0));

  assert_resp_routed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sBValid && sBReady) |-> ($countones(mBValid) == 1));
endmodule

bind axil_rr_share axil_rr_share_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .grantQ(grantQ),
  .mAwReady(mAwReady), .mWReady(mWReady), .mBValid(mBValid),
  .mArReady(mArReady), .mRValid(mRValid),
  .sAwValid(sAwValid), .sWValid(sWValid), .sArValid(sArValid),
  .sBValid(sBValid), .sBReady(sBReady), .sRValid(sRValid), .sRReady(sRReady)
);

// File: tb/sim_axil_rr_share.sv
`timescale 1ns/1ps
module sim_axil_rr_share;
  localparam int N  = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam logic [31:0] RKEY = 32'hC0DE_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] mAwValid, mAwReady, mWValid, mWReady, mBValid, mBReady;
  logic [N-1:0] mArValid, mArReady, mRValid, mRReady;
  logic [N*AW-1:0] mAwAddr, mArAddr;
  logic [N*DW-1:0] mWData;
  logic [N*SW-1:0] mWStrb;
  logic [1:0] mBResp, mRResp, sBResp, sRResp;
  logic [DW-1:0] mRData, sRData, sWData;
  logic sAwValid, sAwReady, sWValid, sWReady, sBValid, sBReady;
  logic sArValid, sArReady, sRValid, sRReady;
  logic [AW-1:0] sAwAddr, sArAddr;
  logic [SW-1:0] sWStrb;

  axil_rr_share #(.N(N), .AW(AW), .DW(DW)) u0 (.*);

  int errors = 0;
  int checks = 0;
  int wrLat = 0, rdLat = 0;
  int wrN = 0, rdN = 0;
  logic [31:0] wrLogA [64];
  logic [31:0] wrLogD [64];
  logic [31:0] rdLog  [64];
  int wrDoneCnt [N];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- slave model: write side ----------------
  initial begin
    sAwReady = 0; sWReady = 0; sBValid = 0; sBResp = 2'b00;
    @(negedge clk);
    forever begin
      #1;
      if (sAwValid && sWValid) begin
        sAwReady = 1; sWReady = 1;
        @(posedge clk);
        wrLogA[wrN] = sAwAddr; wrLogD[wrN] = sWData; wrN++;
        @(negedge clk);
        sAwReady = 0; sWReady = 0;
        repeat (wrLat) @(negedge clk);
        sBValid = 1;
        forever begin #1; if (sBReady) break; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        sBValid = 0;
      end else @(negedge clk);
    end
  end

  // ---------------- slave model: read side ----------------
  initial begin
    logic [31:0] a;
    sArReady = 0; sRValid = 0; sRData = '0; sRResp = 2'b00;
    @(negedge clk);
    forever begin
      #1;
      if (sArValid) begin
        sArReady = 1;
        @(posedge clk);
        a = sArAddr; rdLog[rdN] = a; rdN++;
        @(negedge clk);
        sArReady = 0;
        repeat (rdLat) @(negedge clk);
        sRValid = 1; sRData = a ^ RKEY;
        forever begin #1; if (sRReady) break; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        sRValid = 0; sRData = '0;
      end else @(negedge clk);
    end
  end

  // ---------------- master-side helpers (called at a negedge) ----------------
  task automatic mWrite(input int i, input logic [31:0] a, input logic [31:0] d);
    mAwValid[i] = 1; mAwAddr[i*AW +: AW] = a;
    mWValid[i] = 1; mWData[i*DW +: DW] = d; mWStrb[i*SW +: SW] = '1;
    forever begin #2; if (mAwReady[i] && mWReady[i]) break; @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    mAwValid[i] = 0; mWValid[i] = 0; mBReady[i] = 1;
    forever begin #2; if (mBValid[i]) break; @(negedge clk); end
    check(mBResp == 2'b00, "R7 write response code", 32'(mBResp), 32'h0);
    @(posedge clk);
    @(negedge clk);
    mBReady[i] = 0;
    wrDoneCnt[i]++;
  endtask

  task automatic mRead(input int i, input logic [31:0] a);
    mArValid[i] = 1; mArAddr[i*AW +: AW] = a;
    forever begin #2; if (mArReady[i]) break; @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    mArValid[i] = 0; mRReady[i] = 1;
    forever begin #2; if (mRValid[i]) break; @(negedge clk); end
    check(mRData == (a ^ RKEY) && mRResp == 2'b00, "R7 read data steered", mRData, a ^ RKEY);
    @(posedge clk);
    @(negedge clk);
    mRReady[i] = 0;
  endtask

  task automatic stream(input int i, input bit isWr, input int gap);
    for (int k = 0; k < 4; k++) begin
      if (isWr) mWrite(i, 32'(i * 'h100 + k), 32'(32'hD000 + i * 'h100 + k));
      else      mRead(i, 32'(i * 'h100 + k));
      repeat (gap) @(negedge clk);
    end
  endtask

  // All three masters stream 4 accesses; slave-side order is compared.
  task automatic runOrder(input bit isWr, input int gap, input int lat, input string tag);
    logic [31:0] exp;
    int m, k;
    @(negedge clk);
    wrLat = lat; rdLat = lat; wrN = 0; rdN = 0;
    fork
      stream(0, isWr, gap);
      stream(1, isWr, gap);
      stream(2, isWr, gap);
    join
    check((isWr ? wrN : rdN) == 12, {tag, " access count"}, 32'(isWr ? wrN : rdN), 32'd12);
    for (int j = 0; j < 12; j++) begin
      if (gap == 0) begin m = j / 4; k = j % 4; end
      else          begin m = j % 3; k = j / 3; end
      exp = 32'(m * 'h100 + k);
      if (isWr) begin
        check(wrLogA[j] == exp, {tag, " write order"}, wrLogA[j], exp);
        check(wrLogD[j] == (32'hD000 + exp), "R1 write data passed", wrLogD[j], 32'hD000 + exp);
      end else begin
        check(rdLog[j] == exp, {tag, " read order"}, rdLog[j], exp);
      end
    end
  endtask

  // Second master requests while first waits on a slow response.
  task automatic holdCheck;
    int viol = 0;
    int base;
    @(negedge clk);
    wrLat = 3; wrN = 0; base = wrDoneCnt[0];
    fork
      mWrite(0, 32'h40, 32'h1111);
      begin @(negedge clk); @(negedge clk); mWrite(1, 32'h140, 32'h2222); end
      begin
        repeat (25) begin
          @(negedge clk); #3;
          if (wrDoneCnt[0] == base && (mAwReady[1] || mWReady[1] || mBValid[1])) viol++;
          if (wrDoneCnt[0] == base && mAwValid[1] && sAwValid) viol++;
        end
      end
    join
    check(viol == 0, "R2 other master blocked during locked grant", 32'(viol), 32'd0);
    check(wrLogA[0] == 32'h40 && wrLogA[1] == 32'h140, "R2 lock order", wrLogA[1], 32'h140);
  endtask

  // Write from master 0 and read from master 1 overlap.
  task automatic concurrentCheck;
    bit seen = 0;
    @(negedge clk);
    wrLat = 2; rdLat = 2;
    fork
      mWrite(0, 32'h80, 32'h3333);
      mRead(1, 32'h180);
      begin
        repeat (15) begin
          @(negedge clk); #3;
          if (mBValid[0] && mRValid[1]) seen = 1;
        end
      end
    join
    check(seen, "R6 read and write paths concurrent", 32'(seen), 32'd1);
  endtask

  task automatic resetCheck;
    check(mAwReady == '0 && mWReady == '0 && mArReady == '0, "R8 readies low after reset",
          32'({mAwReady, mWReady, mArReady}), 32'h0);
    check(mBValid == '0 && mRValid == '0, "R8 response valids low after reset",
          32'({mBValid, mRValid}), 32'h0);
    check(!sAwValid && !sWValid && !sArValid, "R5 slave idle after reset",
          32'({sAwValid, sWValid, sArValid}), 32'h0);
  endtask

  task automatic idleCheck;
    repeat (5) begin
      @(negedge clk); #3;
      check(!sAwValid && !sWValid && !sArValid && mBValid == '0 && mRValid == '0,
            "R5 no request, slave side quiet", 32'({sAwValid, sWValid, sArValid}), 32'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) wrDoneCnt[i] = 0;
    mAwValid = '0; mWValid = '0; mBReady = '0; mArValid = '0; mRReady = '0;
    mAwAddr = '0; mArAddr = '0; mWData = '0; mWStrb = '0;
    repeat (5) @(negedge clk);
    #3;
    resetCheck();
    rstN = 1'b1;
    @(negedge clk); #3;
    resetCheck();
    runOrder(1'b1, 0, 0, "R3 R8");
    runOrder(1'b0, 0, 0, "R6 R3");
    runOrder(1'b1, 1, 0, "R4");
    runOrder(1'b0, 1, 0, "R6 R4");
    runOrder(1'b1, 0, 3, "R2");
    runOrder(1'b0, 1, 3, "R6 R2");
    holdCheck();
    concurrentCheck();
    idleCheck();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule